// File: doc/BRIEF.md
# Multiplexed Grid Scan and Duty Timer

This block drives the time-multiplexing of a 16-grid vacuum fluorescent display. It divides the system clock into base ticks, cuts time into fixed digit slots of 64 ticks, and steps a one-hot grid strobe from the first grid upward. On every step it presents the current digit index, which the surrounding logic uses to read display memory.

Contrast is controlled by how much of each slot is lit. A 3-bit duty code selects a lit window at the start of every slot, and the remainder of the slot is blanked. A 3-bit digit-count code shortens the scan to between 9 and 16 grids.

Both codes are sampled only when the scan wraps back to the first grid. This means a change never produces a truncated slot or a partial frame.

Top module: `grid_scan_timer`

## Requirements
- R1: After reset the digit index is 0, only grid 0 is enabled and the segment window is open. The active duty code and digit code are both 0 until the first frame wrap, whatever the code inputs hold.
- R2: One base tick lasts TICK_DIV clocks and one digit slot lasts 64 ticks. The digit index therefore advances every 64·TICK_DIV clocks.
- R3: With active duty code D (0..7), the segment window is high for the first 4·(8+D) ticks of each slot and low for the rest. D=0 gives 32 lit ticks and D=7 gives 60 lit ticks followed by 4 blank ticks.
- R4: At most one grid enable is high at any time. Bit n of grid_en is high exactly when digit_idx equals n and the segment window is high, so every grid is off during blanking.
- R5: The active digit code K selects the scan length: 16 grids when K=0, and K+8 grids when K is 1..7. The index never reaches the scan length, grids at or above it stay off, and the index wraps from the last grid to 0.
- R6: The digit index steps upward by exactly one per slot, except at the wrap, where it returns to 0.
- R7: Changes on duty_code and digits_code take effect only at the clock edge on which the index wraps to 0. Slots already under way in the current frame keep the old values.
- R8: One frame lasts (scan length)·64 ticks, which is 1024 ticks at 16 grids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at the oscillator rate |
| rst | input | 1 | Synchronous reset, active high |
| duty_code | input | 3 | Requested contrast step D; lit ticks per slot are 4·(8+D) |
| digits_code | input | 3 | Requested scan length: 0 selects 16 grids, K selects K+8 grids |
| grid_en | output | NUM_GRIDS | One-hot grid strobe, gated by the segment window |
| digit_idx | output | 4 | Index of the grid in the current slot |
| seg_window | output | 1 | High while the segments of the current slot may be lit |

## Verification
The bench builds the block with TICK_DIV=2 and keeps NUM_GRIDS=16, SLOT_TICKS=64 and STEP_TICKS=4. The shorter tick makes a full 16-slot frame 2048 clocks long, so several complete frames fit in one run. That brings into reach the scan-length switches, the wrap from the last enabled grid, deferral across a whole frame, and the two extreme duty codes. Each check compares a measured count of clocks per slot, lit clocks, or slots per frame against the formulas of the requirements.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;

    localparam int CODE_W    = 3;
    localparam int BASE_STEP = 8;   // duty steps that are always lit

    typedef struct packed {
        logic [CODE_W-1:0] duty;
        logic [CODE_W-1:0] digits;
    } scan_cfg_t;

    // number of grids scanned for a digit-count code
    function automatic int grids_for_code(input logic [CODE_W-1:0] k, input int max_grids);
        if (k == '0)
            return max_grids;
        return max_grids - BASE_STEP + int'(k);
    endfunction

    // lit ticks per slot for a duty code
    function automatic int lit_ticks(input logic [CODE_W-1:0] d, input int step_ticks);
        return step_ticks * (BASE_STEP + int'(d));
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt == CW'(TICK_DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import grid_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = 16,
    parameter int SLOT_TICKS = 64,
    localparam int DIG_W     = $clog2(NUM_GRIDS),
    localparam int POS_W     = $clog2(SLOT_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  scan_cfg_t        cfg_req,
    output logic [POS_W-1:0] slot_pos,
    output logic [DIG_W-1:0] digit,
    output logic [DIG_W:0]   active_grids,
    output scan_cfg_t        cfg_act
);
    logic slot_end;
    logic last_digit;

    assign active_grids = (DIG_W+1)'(grids_for_code(cfg_act.digits, NUM_GRIDS));
    assign slot_end     = tick && (slot_pos == POS_W'(SLOT_TICKS - 1));
    assign last_digit   = ({1'b0, digit} == active_grids - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_pos <= '0;
            digit    <= '0;
            cfg_act  <= '0;
        end else if (tick) begin
            if (slot_end) begin
                slot_pos <= '0;
                if (last_digit) begin
                    digit   <= '0;
                    cfg_act <= cfg_req;   // settings load only at the frame wrap
                end else begin
                    digit <= digit + 1'b1;
                end
            end else begin
                slot_pos <= slot_pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/window_decoder.sv
module window_decoder
    import grid_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = 16,
    parameter int SLOT_TICKS = 64,
    parameter int STEP_TICKS = 4,
    localparam int DIG_W     = $clog2(NUM_GRIDS),
    localparam int POS_W     = $clog2(SLOT_TICKS)
) (
    input  logic [POS_W-1:0]     slot_pos,
    input  logic [DIG_W-1:0]     digit,
    input  logic [CODE_W-1:0]    duty,
    output logic                 seg_window,
    output logic [NUM_GRIDS-1:0] grid_en
);
    logic [POS_W:0] lit_len;

    assign lit_len    = (POS_W+1)'(lit_ticks(duty, STEP_TICKS));
    assign seg_window = ({1'b0, slot_pos} < lit_len);

    generate
        for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
            assign grid_en[g] = seg_window && (digit == DIG_W'(g));
        end
    endgenerate
endmodule

// File: rtl/grid_scan_timer.sv
module grid_scan_timer
    import grid_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = 16,
    parameter int TICK_DIV   = 8,
    parameter int SLOT_TICKS = 64,
    parameter int STEP_TICKS = 4,
    localparam int DIG_W     = $clog2(NUM_GRIDS),
    localparam int POS_W     = $clog2(SLOT_TICKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           duty_code,
    input  logic [2:0]           digits_code,
    output logic [NUM_GRIDS-1:0] grid_en,
    output logic [DIG_W-1:0]     digit_idx,
    output logic                 seg_window
);
    logic             tick;
    logic [POS_W-1:0] slot_pos;
    logic [DIG_W:0]   active_grids;
    scan_cfg_t        cfg_req;
    scan_cfg_t        cfg_act;

    assign cfg_req.duty   = duty_code;
    assign cfg_req.digits = digits_code;

    tick_prescaler #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    slot_sequencer #(.NUM_GRIDS(NUM_GRIDS), .SLOT_TICKS(SLOT_TICKS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .cfg_req      (cfg_req),
        .slot_pos     (slot_pos),
        .digit        (digit_idx),
        .active_grids (active_grids),
        .cfg_act      (cfg_act)
    );

    window_decoder #(
        .NUM_GRIDS  (NUM_GRIDS),
        .SLOT_TICKS (SLOT_TICKS),
        .STEP_TICKS (STEP_TICKS)
    ) u_win (
        .slot_pos   (slot_pos),
        .digit      (digit_idx),
        .duty       (cfg_act.duty),
        .seg_window (seg_window),
        .grid_en    (grid_en)
    );
endmodule

// File: rtl/grid_scan_checker.sv
module grid_scan_checker
    import grid_scan_pkg::*;
#(
    parameter int NUM_GRIDS = 16,
    localparam int DIG_W    = $clog2(NUM_GRIDS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_GRIDS-1:0] grid_en,
    input logic [DIG_W-1:0]     digit_idx,
    input logic                 seg_window,
    input logic [DIG_W:0]       active_grids,
    input scan_cfg_t            cfg_act
);
    AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grid_en)); // R4

    AST_BLANK_GRIDS_OFF: assert property (@(posedge clk) disable iff (rst)
        !seg_window |-> (grid_en == '0)); // R4

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, digit_idx} < active_grids)); // R5

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        (digit_idx != $past(digit_idx)) |->
            (digit_idx == $past(digit_idx) + 1'b1 || digit_idx == '0)); // R6

    AST_SLOT_STARTS_LIT: assert property (@(posedge clk) disable iff (rst)
        (digit_idx != $past(digit_idx)) |-> seg_window); // R3

    AST_WINDOW_RISE_AT_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(seg_window) |-> (digit_idx != $past(digit_idx))); // R2

    AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cfg_act != $past(cfg_act)) |->
            (digit_idx == '0 && $past(digit_idx) != '0)); // R7
endmodule

bind grid_scan_timer grid_scan_checker #(.NUM_GRIDS(NUM_GRIDS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .grid_en      (grid_en),
    .digit_idx    (digit_idx),
    .seg_window   (seg_window),
    .active_grids (active_grids),
    .cfg_act      (cfg_act)
);

// File: tb/grid_scan_timer_test.sv
`timescale 1ns/1ps
module grid_scan_timer_test;
    localparam int NG  = 16;
    localparam int TD  = 2;
    localparam int SL  = 64;
    localparam int SLOT_CLK = SL * TD;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    duty_code = 3'd0;
    logic [2:0]    digits_code = 3'd0;
    logic [NG-1:0] grid_en;
    logic [3:0]    digit_idx;
    logic          seg_window;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [NG-1:0] seen_mask;

    always #10 clk = ~clk;   // 50 MHz

    grid_scan_timer #(.NUM_GRIDS(NG), .TICK_DIV(TD), .SLOT_TICKS(SL), .STEP_TICKS(4)) uut (
        .clk         (clk),
        .rst         (rst),
        .duty_code   (duty_code),
        .digits_code (digits_code),
        .grid_en     (grid_en),
        .digit_idx   (digit_idx),
        .seg_window  (seg_window)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // waits until the index has just changed to v
    task automatic wait_digit(input int v);
        while (int'(digit_idx) == v) @(negedge clk);
        while (int'(digit_idx) != v) @(negedge clk);
    endtask

    // measures one slot starting at its first clock
    task automatic measure_slot(output int d, output int lit, output int len, output int gate_err);
        d = int'(digit_idx);
        lit = 0; len = 0; gate_err = 0;
        do begin
            seen_mask |= grid_en;
            if (seg_window) begin
                lit++;
                if (grid_en != NG'(1) << d) gate_err++;
            end else if (grid_en != '0) begin
                gate_err++;
            end
            len++;
            @(negedge clk);
        end while (int'(digit_idx) == d);
    endtask

    task automatic t_reset_and_timing();
        int n;
        duty_code = 3'd0; digits_code = 3'd0;
        do_reset();
        chk(digit_idx == 4'd0, "R1 index after reset", digit_idx, 0);
        chk(grid_en == 16'h0001, "R1 grid after reset", grid_en, 1);
        chk(seg_window == 1'b1, "R1 window after reset", seg_window, 1);
        n = 0;
        while (seg_window) begin @(negedge clk); n++; end
        chk(n == 32 * TD, "R3 lit clocks duty 0", n, 32 * TD);
        chk(grid_en == '0, "R4 grids off in blank", grid_en, 0);
        while (digit_idx == 4'd0) begin @(negedge clk); n++; end
        chk(n == SLOT_CLK, "R2 slot length", n, SLOT_CLK);
        chk(digit_idx == 4'd1, "R6 next index", digit_idx, 1);
        chk(grid_en == 16'h0002, "R4 grid 1 strobe", grid_en, 2);
    endtask

    task automatic t_duty(input logic [2:0] d);
        int di, lit, len, ge;
        duty_code = d;
        wait_digit(0);
        measure_slot(di, lit, len, ge);
        chk(lit == 4 * (8 + int'(d)) * TD, "R3 lit clocks", lit, 4 * (8 + int'(d)) * TD);
        chk(len == SLOT_CLK, "R2 slot clocks", len, SLOT_CLK);
        chk(ge == 0, "R4 grid gating errors", ge, 0);
    endtask

    task automatic t_digits(input logic [2:0] k);
        int di, lit, len, ge, sum, ng;
        ng = (k == 3'd0) ? 16 : int'(k) + 8;
        digits_code = k;
        wait_digit(0);
        seen_mask = '0;
        sum = 0;
        for (int i = 0; i < ng; i++) begin
            measure_slot(di, lit, len, ge);
            sum += len;
            chk(di == i, "R6 scan order", di, i);
        end
        chk(digit_idx == 4'd0, "R5 wrap to grid 0", digit_idx, 0);
        chk(sum == ng * SLOT_CLK, "R8 frame clocks", sum, ng * SLOT_CLK);
        chk((seen_mask >> ng) == '0, "R5 grids beyond limit off", int'(seen_mask >> ng), 0);
    endtask

    task automatic t_defer();
        int di, lit, len, ge, slots;
        duty_code = 3'd3; digits_code = 3'd0;
        wait_digit(0);
        wait_digit(2);
        duty_code = 3'd7; digits_code = 3'd1;
        measure_slot(di, lit, len, ge);
        chk(lit == 44 * TD, "R7 old duty kept mid-frame", lit, 44 * TD);
        slots = 1;
        while (digit_idx != 4'd0) begin
            measure_slot(di, lit, len, ge);
            slots++;
        end
        chk(slots == 14, "R7 old scan length kept", slots, 14);
        measure_slot(di, lit, len, ge);
        chk(lit == 60 * TD, "R7 new duty after wrap", lit, 60 * TD);
        slots = 1;
        while (digit_idx != 4'd0) begin
            measure_slot(di, lit, len, ge);
            slots++;
        end
        chk(slots == 9, "R7 new scan length after wrap", slots, 9);
    endtask

    task automatic t_reset_defaults();
        int di, lit, len, ge, slots;
        duty_code = 3'd7; digits_code = 3'd2;
        do_reset();
        chk(digit_idx == 4'd0 && grid_en == 16'h0001, "R1 reset mid-run", grid_en, 1);
        measure_slot(di, lit, len, ge);
        chk(lit == 32 * TD, "R1 duty 0 before first wrap", lit, 32 * TD);
        slots = 1;
        while (digit_idx != 4'd0) begin
            measure_slot(di, lit, len, ge);
            slots++;
        end
        chk(slots == 16, "R1 16 grids before first wrap", slots, 16);
    endtask

    initial begin
        t_reset_and_timing();
        t_duty(3'd7);
        t_duty(3'd3);
        t_duty(3'd0);
        t_digits(3'd1);
        t_digits(3'd7);
        t_digits(3'd0);
        t_defer();
        t_reset_defaults();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule